// File: doc/BRIEF.md
# Functional Unit Issue Scoreboard

This block sits in the issue stage of an in-order-issue, out-of-order-completion pipeline. It decides, each cycle, whether the decoded instruction may leave for its functional unit. Four units are modelled: a combinational ALU (latency 1), a pipelined multiplier (latency `MUL_LAT`), a pipelined bit-manipulation unit (latency `BMU_LAT`) and a non-pipelined divider (latency `DIV_LAT`). For every operation in flight the block keeps the destination register and a countdown of the cycles left until its result is valid. The divider also carries a busy flag, because it accepts one operation at a time.

For each source register the block looks for the youngest in-flight write to that register. If that write is due within `FWD_WIN` cycles, the operand is forwarded from the producing unit. If the write is due later, the instruction stalls. If there is no such write, the operand comes from the register file. A destination that collides with a slower in-flight write also stalls, and so does a divider operation while the divider is busy. A downstream hold freezes every countdown. A flush empties all tracking.

Top module: `fu_scoreboard`

## Requirements
- R1: After reset, and in the cycle after `flush` is high, nothing is in flight: any valid instruction issues with both forwarding selects 0 (register file). While `flush` is high, `issue_ok` and `stall` are both 0.
- R2: Register 0 is never a dependency. A source index of 0 always gives select 0, and a destination of 0 never causes a write-after-write stall.
- R3: A forwarding select is 3 bits: bit 2 set means forward, and bits 1:0 give the producing unit (0 ALU, 1 MUL, 2 BMU, 3 DIV). A source whose youngest matching in-flight write has at most `FWD_WIN` (default 1) cycles left gets select {1, unit}.
- R4: A source whose youngest matching in-flight write has more than `FWD_WIN` cycles left makes `issue_ok` 0 and `stall` 1.
- R5: When several in-flight writes target the same register, only the most recently issued one decides between forwarding and stalling.
- R6: A destination that matches an in-flight write with at least as many cycles left as the new unit's latency stalls the instruction.
- R7: After a divider operation issues, every further divider operation stalls for `DIV_LAT` unstalled cycles. It issues in the cycle after that.
- R8: While `pipe_hold` is high, nothing issues, a valid instruction shows `stall`, and no countdown advances.
- R9: An operation issued to a unit of latency L becomes forwardable L-1 unstalled cycles after its issue edge. A dependent that arrives earlier stalls.
- R10: `stall` equals `dec_valid` and not `flush` and not `issue_ok`. `issue_ok` and `stall` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Pipeline flush: clears all in-flight tracking |
| pipe_hold | input | 1 | Downstream hold: freezes countdowns, blocks issue |
| dec_valid | input | 1 | Decoded instruction present |
| dec_unit | input | 2 | Target unit (0 ALU, 1 MUL, 2 BMU, 3 DIV) |
| dec_rs1 | input | RW | First source register index |
| dec_rs2 | input | RW | Second source register index |
| dec_rd | input | RW | Destination register index (0 = no write) |
| issue_ok | output | 1 | Instruction issues at this clock edge |
| stall | output | 1 | Valid instruction held in issue |
| fwd_rs1 | output | 3 | Operand source for rs1 |
| fwd_rs2 | output | 3 | Operand source for rs2 |

## Verification
All four outputs are combinational in the current inputs and the tracked state. The bench therefore drives each instruction on a falling edge and compares `issue_ok`, `stall` and both selects 1 ns later, within the same cycle. An issue, hold or flush changes the state at the next rising edge, so its effect is due in the following cycle. A multiplier result is forwardable `MUL_LAT`-1 unstalled cycles after that edge, and the divider is free again after `DIV_LAT`. The bench's list-based model advances at the same edge, so each expectation belongs to the cycle being checked. Directed runs pin down those exact cycle counts, and a seeded random run mixes holds and flushes.

// File: rtl/sb_pkg.sv
package sb_pkg;
   localparam int NUM_UNITS = 4;
   localparam int UNIT_W    = 2;

   typedef enum logic [UNIT_W-1:0] {
      FU_ALU = 2'd0,
      FU_MUL = 2'd1,
      FU_BMU = 2'd2,
      FU_DIV = 2'd3
   } fu_e;

   function automatic int fu_lat(input int u, input int mul, input int bmu, input int div);
      case (u)
         0:       return 1;
         1:       return mul;
         2:       return bmu;
         default: return div;
      endcase
   endfunction

   function automatic bit fu_piped(input int u);
      return u != 3;
   endfunction

   function automatic int fu_slots(input int u, input int mul, input int bmu, input int div);
      return fu_piped(u) ? fu_lat(u, mul, bmu, div) : 1;
   endfunction

   function automatic int fu_base(input int u, input int mul, input int bmu, input int div);
      int acc;
      acc = 0;
      for (int k = 0; k < u; k++) acc += fu_slots(k, mul, bmu, div);
      return acc;
   endfunction

   function automatic int max_lat(input int mul, input int bmu, input int div);
      int m;
      m = 1;
      if (mul > m) m = mul;
      if (bmu > m) m = bmu;
      if (div > m) m = div;
      return m;
   endfunction
endpackage

// File: rtl/sb_unit_track.sv
module sb_unit_track #(
   parameter int LAT   = 3,
   parameter bit PIPED = 1'b1,
   parameter int RW    = 5,
   parameter int CW    = 4,
   parameter int SLOTS = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          adv,
   input  logic          load,
   input  logic [RW-1:0] load_rd,
   output logic          slot_vld [SLOTS],
   output logic [RW-1:0] slot_rd  [SLOTS],
   output logic [CW-1:0] slot_rem [SLOTS],
   output logic          blocked
);

   if (LAT < 1 || (PIPED && SLOTS != LAT) || (!PIPED && SLOTS != 1) || (1 << CW) <= LAT) begin : g_bad_cfg
      $error("sb_unit_track: inconsistent LAT/SLOTS/CW");
   end

   if (PIPED) begin : g_pipe
      logic          vld_q [SLOTS];
      logic [RW-1:0] rd_q  [SLOTS];
      logic          vld_n [SLOTS];
      logic [RW-1:0] rd_n  [SLOTS];

      for (genvar i = 0; i < SLOTS; i++) begin : g_slot
         if (i == SLOTS - 1) begin : g_top
            assign vld_n[i] = load;
            assign rd_n[i]  = load_rd;
         end else begin : g_mid
            assign vld_n[i] = vld_q[i+1];
            assign rd_n[i]  = rd_q[i+1];
         end
         assign slot_vld[i] = vld_q[i];
         assign slot_rd[i]  = rd_q[i];
         assign slot_rem[i] = CW'(i + 1);
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) begin
               vld_q[i] <= 1'b0;
               rd_q[i]  <= '0;
            end
         end else if (flush) begin
            for (int i = 0; i < SLOTS; i++) vld_q[i] <= 1'b0;
         end else if (adv) begin
            for (int i = 0; i < SLOTS; i++) begin
               vld_q[i] <= vld_n[i];
               rd_q[i]  <= rd_n[i];
            end
         end
      end

      assign blocked = 1'b0;

      // R9
      pipe_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (adv && !flush && load) |=> vld_q[SLOTS-1]);
   end else begin : g_multi
      logic [CW-1:0] cnt_q;
      logic          busy_q;
      logic [RW-1:0] rd_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
            rd_q   <= '0;
         end else if (flush) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
         end else if (adv) begin
            if (load) begin
               cnt_q  <= CW'(LAT);
               busy_q <= 1'b1;
               rd_q   <= load_rd;
            end else if (busy_q) begin
               cnt_q <= cnt_q - 1'b1;
               if (cnt_q == CW'(1)) busy_q <= 1'b0;
            end
         end
      end

      assign slot_vld[0] = busy_q;
      assign slot_rd[0]  = rd_q;
      assign slot_rem[0] = cnt_q;
      assign blocked     = busy_q;

      // R7
      div_keep_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (busy_q && !flush && !(adv && cnt_q == CW'(1))) |=> busy_q);
      // R7
      div_single_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
         load |-> !busy_q);
   end

endmodule

// File: rtl/fu_scoreboard.sv
module fu_scoreboard
   import sb_pkg::*;
#(
   parameter int RW      = 5,
   parameter int MUL_LAT = 3,
   parameter int BMU_LAT = 2,
   parameter int DIV_LAT = 8,
   parameter int FWD_WIN = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          pipe_hold,
   input  logic          dec_valid,
   input  logic [1:0]    dec_unit,
   input  logic [RW-1:0] dec_rs1,
   input  logic [RW-1:0] dec_rs2,
   input  logic [RW-1:0] dec_rd,
   output logic          issue_ok,
   output logic          stall,
   output logic [2:0]    fwd_rs1,
   output logic [2:0]    fwd_rs2
);

   localparam int MAXL = max_lat(MUL_LAT, BMU_LAT, DIV_LAT);
   localparam int CW   = $clog2(MAXL + 1);
   localparam int TOT  = fu_base(NUM_UNITS, MUL_LAT, BMU_LAT, DIV_LAT);

   if (RW < 1 || MUL_LAT < 1 || BMU_LAT < 1 || DIV_LAT < 2 || FWD_WIN < 1) begin : g_bad_cfg
      $error("fu_scoreboard: illegal parameter set");
   end

   logic [TOT-1:0]       e_vld;
   logic [RW-1:0]        e_rd   [TOT];
   logic [CW-1:0]        e_rem  [TOT];
   logic [CW-1:0]        e_age  [TOT];
   logic [UNIT_W-1:0]    e_unit [TOT];
   logic [NUM_UNITS-1:0] unit_blk;
   logic                 adv;

   assign adv = !pipe_hold;

   for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
      localparam int L    = fu_lat(u, MUL_LAT, BMU_LAT, DIV_LAT);
      localparam int SL   = fu_slots(u, MUL_LAT, BMU_LAT, DIV_LAT);
      localparam int BASE = fu_base(u, MUL_LAT, BMU_LAT, DIV_LAT);
      logic          sv [SL];
      logic [RW-1:0] sr [SL];
      logic [CW-1:0] sm [SL];

      sb_unit_track #(
         .LAT(L), .PIPED(fu_piped(u)), .RW(RW), .CW(CW), .SLOTS(SL)
      ) u_track (
         .clk      (clk),
         .rst_n    (rst_n),
         .flush    (flush),
         .adv      (adv),
         .load     (issue_ok && dec_unit == UNIT_W'(u)),
         .load_rd  (dec_rd),
         .slot_vld (sv),
         .slot_rd  (sr),
         .slot_rem (sm),
         .blocked  (unit_blk[u])
      );

      for (genvar j = 0; j < SL; j++) begin : g_ent
         assign e_vld[BASE+j]  = sv[j];
         assign e_rd[BASE+j]   = sr[j];
         assign e_rem[BASE+j]  = sm[j];
         assign e_age[BASE+j]  = CW'(L) - sm[j];
         assign e_unit[BASE+j] = UNIT_W'(u);
      end
   end

   // Per-operand youngest-producer search
   for (genvar p = 0; p < 2; p++) begin : g_src
      logic [RW-1:0]     rs;
      logic              hit;
      logic              late;
      logic [UNIT_W-1:0] unit;
      logic [CW-1:0]     best_age;
      logic [CW-1:0]     best_rem;

      assign rs = (p == 0) ? dec_rs1 : dec_rs2;

      always_comb begin
         hit      = 1'b0;
         unit     = '0;
         best_age = '0;
         best_rem = '0;
         for (int k = 0; k < TOT; k++) begin
            if (e_vld[k] && rs != '0 && e_rd[k] == rs && (!hit || e_age[k] < best_age)) begin
               hit      = 1'b1;
               best_age = e_age[k];
               best_rem = e_rem[k];
               unit     = e_unit[k];
            end
         end
         late = hit && (int'(best_rem) > FWD_WIN);
      end
   end

   logic [CW-1:0] new_lat;
   logic          waw;

   always_comb begin
      new_lat = CW'(fu_lat(int'(dec_unit), MUL_LAT, BMU_LAT, DIV_LAT));
      waw     = 1'b0;
      for (int k = 0; k < TOT; k++) begin
         if (e_vld[k] && dec_rd != '0 && e_rd[k] == dec_rd && e_rem[k] >= new_lat) waw = 1'b1;
      end
   end

   logic hazard;
   assign hazard   = g_src[0].late || g_src[1].late || waw || unit_blk[dec_unit];
   assign issue_ok = dec_valid && !flush && !pipe_hold && !hazard;
   assign stall    = dec_valid && !flush && !issue_ok;
   assign fwd_rs1  = (g_src[0].hit && !g_src[0].late) ? {1'b1, g_src[0].unit} : 3'b000;
   assign fwd_rs2  = (g_src[1].hit && !g_src[1].late) ? {1'b1, g_src[1].unit} : 3'b000;

   // R10
   issue_stall_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(issue_ok && stall));
   // R8
   hold_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pipe_hold |-> !issue_ok);
   // R8
   hold_freezes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pipe_hold && !flush) |=> $stable(unit_blk));
   // R1
   flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (unit_blk == '0));
   // R2
   x0_no_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_rs1 == '0) |-> (fwd_rs1 == 3'b000));

endmodule

// File: tb/fu_scoreboard_test.sv
module fu_scoreboard_test;
   localparam int RW = 5, MUL_LAT = 3, BMU_LAT = 2, DIV_LAT = 8;
   localparam int NOPS = 32;

   logic clk = 1'b0, rst_n = 1'b0;
   logic flush = 0, pipe_hold = 0, dec_valid = 0;
   logic [1:0] dec_unit = 0;
   logic [RW-1:0] dec_rs1 = 0, dec_rs2 = 0, dec_rd = 0;
   logic issue_ok, stall;
   logic [2:0] fwd_rs1, fwd_rs2;

   int checks = 0, errors = 0;
   bit done = 0;

   // model of in-flight operations
   bit m_v [NOPS];
   int m_u [NOPS], m_rd [NOPS], m_rem [NOPS], m_seq [NOPS];
   int seq_ctr = 0;

   always #2 clk = ~clk;

   fu_scoreboard #(.RW(RW), .MUL_LAT(MUL_LAT), .BMU_LAT(BMU_LAT), .DIV_LAT(DIV_LAT), .FWD_WIN(1)) uut (
      .clk(clk), .rst_n(rst_n), .flush(flush), .pipe_hold(pipe_hold), .dec_valid(dec_valid),
      .dec_unit(dec_unit), .dec_rs1(dec_rs1), .dec_rs2(dec_rs2), .dec_rd(dec_rd),
      .issue_ok(issue_ok), .stall(stall), .fwd_rs1(fwd_rs1), .fwd_rs2(fwd_rs2));

   function automatic int lat_of(input int u);
      case (u) 0: return 1; 1: return MUL_LAT; 2: return BMU_LAT; default: return DIV_LAT; endcase
   endfunction

   // returns select (0 / 4+unit) or -1 when late
   function automatic int src_sel(input int rs);
      int best, bs;
      best = -1; bs = -1;
      if (rs == 0) return 0;
      for (int i = 0; i < NOPS; i++)
         if (m_v[i] && m_rd[i] == rs && m_seq[i] > bs) begin bs = m_seq[i]; best = i; end
      if (best < 0) return 0;
      if (m_rem[best] > 1) return -1;
      return 4 + m_u[best];
   endfunction

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic step(input bit v, input int u, input int rs1, input int rs2, input int rd,
                       input bit hold, input bit fl, input string tag,
                       input int want_issue = -1, input int want_f1 = -1);
      int s1, s2, e_iss, e_stl, f1, f2;
      bit waw, busy;
      @(negedge clk);
      dec_valid = v; dec_unit = 2'(u); dec_rs1 = RW'(rs1); dec_rs2 = RW'(rs2); dec_rd = RW'(rd);
      pipe_hold = hold; flush = fl;
      #1;
      s1 = src_sel(rs1); s2 = src_sel(rs2);
      waw = 0; busy = 0;
      for (int i = 0; i < NOPS; i++) begin
         if (m_v[i] && rd != 0 && m_rd[i] == rd && m_rem[i] >= lat_of(u)) waw = 1;
         if (m_v[i] && m_u[i] == 3) busy = 1;
      end
      e_iss = (v && !fl && !hold && s1 >= 0 && s2 >= 0 && !waw && !(u == 3 && busy)) ? 1 : 0;
      e_stl = (v && !fl && !e_iss) ? 1 : 0;
      f1 = (s1 < 0) ? 0 : s1;
      f2 = (s2 < 0) ? 0 : s2;
      chk(tag, "issue_ok", int'(issue_ok), e_iss);
      chk("R10", "stall", int'(stall), e_stl);
      chk(tag, "fwd_rs1", int'(fwd_rs1), f1);
      chk(tag, "fwd_rs2", int'(fwd_rs2), f2);
      if (want_issue >= 0) chk(tag, "issue_ok(directed)", int'(issue_ok), want_issue);
      if (want_f1 >= 0) chk(tag, "fwd_rs1(directed)", int'(fwd_rs1), want_f1);
      @(posedge clk);
      if (fl) begin
         for (int i = 0; i < NOPS; i++) m_v[i] = 0;
      end else if (!hold) begin
         for (int i = 0; i < NOPS; i++)
            if (m_v[i]) begin m_rem[i]--; if (m_rem[i] == 0) m_v[i] = 0; end
         if (e_iss == 1) begin
            for (int i = 0; i < NOPS; i++)
               if (!m_v[i]) begin
                  m_v[i] = 1; m_u[i] = u; m_rd[i] = rd; m_rem[i] = lat_of(u); m_seq[i] = seq_ctr++;
                  break;
               end
         end
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, "R1");
   endtask

   initial begin
      for (int i = 0; i < NOPS; i++) m_v[i] = 0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // R1 reset state
      step(0, 0, 0, 0, 0, 0, 0, "R1", 0);
      step(1, 0, 1, 2, 3, 0, 0, "R1", 1, 0);
      // R3 back-to-back ALU forwarding
      step(1, 0, 3, 0, 4, 0, 0, "R3", 1, 4);
      // R9 multiplier latency
      step(1, 1, 0, 0, 5, 0, 0, "R9", 1);
      step(1, 0, 5, 0, 7, 0, 0, "R4", 0);
      step(1, 0, 5, 0, 7, 0, 0, "R4", 0);
      step(1, 0, 5, 0, 7, 0, 0, "R9", 1, 5);
      // R2 register 0
      step(1, 1, 0, 0, 0, 0, 0, "R2", 1);
      step(1, 0, 0, 0, 0, 0, 0, "R2", 1, 0);
      idle(3);
      // R7 divider busy window
      step(1, 3, 0, 0, 8, 0, 0, "R7", 1);
      for (int i = 0; i < DIV_LAT; i++) step(1, 3, 0, 0, 9, 0, 0, "R7", 0);
      step(1, 3, 0, 0, 9, 0, 0, "R7", 1);
      // R1 flush
      step(1, 0, 9, 0, 1, 0, 1, "R1", 0);
      step(1, 3, 9, 0, 10, 0, 0, "R1", 1, 0);
      idle(DIV_LAT);
      // R5 youngest producer decides
      step(1, 1, 0, 0, 11, 0, 0, "R5", 1);
      idle(1);
      step(1, 3, 0, 0, 11, 0, 0, "R5", 1);
      step(1, 0, 11, 0, 2, 0, 0, "R5", 0, 0);
      idle(DIV_LAT);
      // R6 write-after-write
      step(1, 1, 0, 0, 12, 0, 0, "R6", 1);
      step(1, 0, 0, 0, 12, 0, 0, "R6", 0);
      idle(3);
      // R8 hold freezes countdowns
      step(1, 1, 0, 0, 13, 0, 0, "R8", 1);
      for (int i = 0; i < 3; i++) step(1, 0, 13, 0, 1, 1, 0, "R8", 0);
      step(1, 0, 13, 0, 1, 0, 0, "R8", 0);
      step(1, 0, 13, 0, 1, 0, 0, "R8", 0);
      step(1, 0, 13, 0, 1, 0, 0, "R8", 1, 5);
      idle(DIV_LAT);
      // seeded random mix
      void'($urandom(32'd20240611));
      for (int n = 0; n < 3000; n++) begin
         step(($urandom % 5) != 0, $urandom % 4, $urandom % 5, $urandom % 5, $urandom % 5,
              ($urandom % 10) == 0, ($urandom % 40) == 0, "R3/R4/R6/R7");
      end
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule